// File: doc/BRIEF.md
# Zero-Crossing Phase Timer

This block sets the phase lag of the resonant inductor current behind the half-bridge midpoint voltage. It takes the digital output of the inductor-current zero-crossing comparator and measures the switching period in clock cycles, from one rising edge to the next. From an unsigned phase command and a measured gate-drive delay it works out, once per cycle, how long after the detected zero crossing the high-side gate must turn off. It then runs the complementary low-side gate with a fixed dead time, and schedules the reverse transition half a period later.

Every edge comes from the period just measured, so the operating point follows the resonant tank as it drifts. The block does not run a free oscillator. It also produces a one-cycle sync pulse on every zero crossing, which downstream peak detection and compensation use as their latch strobe. A sampling strobe locked to the switching period gives the converter 16 or 32 samples per period. When the crossings stop, the block drops both gates and flags loss of sync, so that a fallback oscillator can take over.

Top module: `zc_phase_timer`

## Requirements
- R1: A detecting edge E is a clock edge at which `zc_in` is sampled high after it was sampled low at the previous edge. The period P is the number of clock edges between two consecutive detecting edges. Both gates stay low until two detecting edges have been seen since reset or since loss of sync.
- R2: At each detecting edge the block latches `phase_cmd` (code 0 means no lag, code 2^m-1 means a quarter period of lag) and `gd_cnt`. It forms D = floor(P/2) - floor(P*phase_cmd/2^(m+2)) - gd_cnt, where P is the period that ends at that edge. The high-side gate is low from edge E+D+1 on.
- R3: The low-side gate goes high at edge E+D+1+DEAD_CYC and goes low at edge E+D+1+floor(P/2). The high-side gate goes high again at edge E+D+1+floor(P/2)+DEAD_CYC.
- R4: The two gates are never high in the same cycle. A gate turns on only if the other gate was low in the cycle before, and the low-side gate wins when both would turn on at the same edge.
- R5: `cycle_clk` is high for exactly the one cycle that follows each detecting edge.
- R6: With a steady period longer than 32 cycles, `samp_tick` pulses exactly 16 times between two consecutive `cycle_clk` pulses when `samp_x32` is 0, and exactly 32 times when it is 1. It never pulses in a `cycle_clk` cycle.
- R7: When TIMEOUT_CYC edges pass without a detecting edge, `no_sync` goes high and both gates are forced low. `no_sync` clears at the next detecting edge. After that, two detecting edges are again needed before the gates run.
- R8: A detecting edge replaces any transition still pending from the previous schedule. A transition whose time falls exactly on that edge still takes effect.
- R9: While reset is asserted, all outputs are low.
- R10: When the formula of R2 goes negative, D is clamped to zero, so the high side turns off at edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| zc_in | input | 1 | Inductor-current zero-crossing comparator output |
| phase_cmd | input | CMD_W | Phase lag command, 0 to 2^CMD_W-1 |
| gd_cnt | input | GD_W | Measured gate-drive delay in clock cycles |
| samp_x32 | input | 1 | Sampling strobe rate: 0 gives 16 per period, 1 gives 32 |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| cycle_clk | output | 1 | One-cycle pulse per positive zero crossing |
| samp_tick | output | 1 | Sampling strobe locked to the switching period |
| no_sync | output | 1 | Zero crossings lost; gates held low |

## Verification
The assertions check on every cycle that the gates never overlap and that each gate turns on only after the other has been low. They also check that the sync pulse lasts one cycle and never coincides with a sampling strobe, and that both gates stay quiet while sync is lost, with sync returning only together with a zero-crossing pulse. Only the bench scenarios can show where each gate edge lands against the delay formula at 30 kHz and 300 kHz, the zero clamp, the cancelling of stale transitions when the period shrinks, and the exact strobe count per period at both rates.

// File: rtl/zcpt_pkg.sv
package zcpt_pkg;
   // Gate command pair for the two half-bridge switches.
   typedef struct packed {
      logic hi;
      logic lo;
   } gate_pair_t;
endpackage

// File: rtl/zcpt_period.sv
// Edge detection, period measurement and loss-of-sync detection.
module zcpt_period #(
   parameter int CNT_W       = 16,
   parameter int TIMEOUT_CYC = 4096,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             zc_in,
   output logic             rise,
   output logic             tmo,
   output logic [CNT_W-1:0] meas,
   output logic [CNT_W-1:0] per_q,
   output logic             valid_q,
   output logic             no_sync_q
);
   localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CYC - 1);

   logic             zc_s;
   logic             zc_d;
   logic             primed_q;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign zc_s = zc_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= zc_in;
               for (int i = 1; i < SYNC_STAGES; i++) sh_q[i] <= sh_q[i-1];
            end
         end
         assign zc_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   assign rise = zc_s & ~zc_d;
   assign meas = cnt_q + CNT_W'(1);
   assign tmo  = ~rise & ~no_sync_q & (cnt_q == TMO_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zc_d      <= 1'b0;
         cnt_q     <= '0;
         per_q     <= '0;
         valid_q   <= 1'b0;
         primed_q  <= 1'b0;
         no_sync_q <= 1'b0;
      end else begin
         zc_d <= zc_s;
         if (rise) begin
            cnt_q     <= '0;
            per_q     <= meas;
            valid_q   <= primed_q;
            primed_q  <= 1'b1;
            no_sync_q <= 1'b0;
         end else begin
            if (cnt_q != TMO_LAST) cnt_q <= cnt_q + CNT_W'(1);
            if (tmo) begin
               valid_q   <= 1'b0;
               primed_q  <= 1'b0;
               no_sync_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/zcpt_delay.sv
// Turn-off delay from the measured period, phase command and gate delay.
module zcpt_delay #(
   parameter int CNT_W = 16,
   parameter int CMD_W = 8,
   parameter int GD_W  = 8
) (
   input  logic [CNT_W-1:0] meas,
   input  logic [CMD_W-1:0] cmd,
   input  logic [GD_W-1:0]  tgd,
   output logic [CNT_W-1:0] dly,
   output logic [CNT_W-1:0] half
);
   localparam int PW  = CNT_W + CMD_W;
   localparam int CW1 = CNT_W + 1;

   logic [PW-1:0]    prod;
   logic [CNT_W-1:0] lag;
   logic [CNT_W:0]   diff;

   // cmd/(2^m-1) is approximated by cmd/2^m; the extra /4 maps full scale to a quarter period
   assign prod = PW'(meas) * PW'(cmd);
   assign lag  = CNT_W'(prod >> (CMD_W + 2));
   assign half = meas >> 1;
   assign diff = {1'b0, half} - {1'b0, lag} - CW1'(tgd);
   assign dly  = diff[CNT_W] ? '0 : diff[CNT_W-1:0];
endmodule

// File: rtl/zcpt_gates.sv
// Phase counter and gate sequencer with dead time.
module zcpt_gates
   import zcpt_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int DEAD_CYC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             valid,
   input  logic             tmo,
   input  logic [CNT_W-1:0] dly,
   input  logic [CNT_W-1:0] half,
   output gate_pair_t       gates
);
   localparam int            EW = CNT_W + 2;
   localparam logic [EW-1:0] DT = EW'(DEAD_CYC);

   logic [CNT_W-1:0] tcnt_q, dly_q, half_q;
   logic [EW-1:0]    t_now, t_hi_off, t_lo_on, t_lo_off, t_hi_on;
   logic             ev_hi_off, ev_lo_on, ev_lo_off, ev_hi_on, lo_set;
   gate_pair_t       g_q, g_n;

   assign t_now    = EW'(tcnt_q);
   assign t_hi_off = EW'(dly_q);
   assign t_lo_on  = t_hi_off + DT;
   assign t_lo_off = t_hi_off + EW'(half_q);
   assign t_hi_on  = t_lo_off + DT;

   assign ev_hi_off = valid & (t_now == t_hi_off);
   assign ev_lo_on  = valid & (t_now == t_lo_on);
   assign ev_lo_off = valid & (t_now == t_lo_off);
   assign ev_hi_on  = valid & (t_now == t_hi_on);
   assign lo_set    = ev_lo_on & ~g_q.hi;

   always_comb begin
      g_n = g_q;
      if (ev_hi_off) g_n.hi = 1'b0;
      if (ev_lo_off) g_n.lo = 1'b0;
      if (lo_set)    g_n.lo = 1'b1;
      if (ev_hi_on && !g_q.lo && !lo_set) g_n.hi = 1'b1;
      if (tmo) g_n = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt_q <= '0;
         dly_q  <= '0;
         half_q <= '0;
         g_q    <= '0;
      end else begin
         g_q <= g_n;
         if (rise) begin
            tcnt_q <= '0;
            dly_q  <= dly;
            half_q <= half;
         end else if (tcnt_q != '1) begin
            tcnt_q <= tcnt_q + CNT_W'(1);
         end
      end
   end

   assign gates = g_q;
endmodule

// File: rtl/zcpt_sampler.sv
// Fractional accumulator giving 16 or 32 strobes per measured period.
module zcpt_sampler #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             valid,
   input  logic             x32,
   input  logic [CNT_W-1:0] per,
   output logic             tick
);
   localparam int AW = CNT_W + 1;

   logic [AW-1:0] acc_q, step, sum, per_x;

   assign step  = x32 ? AW'(32) : AW'(16);
   assign sum   = acc_q + step;
   assign per_x = AW'(per);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         tick  <= 1'b0;
      end else if (rise) begin
         acc_q <= step;
         tick  <= 1'b0;
      end else if (valid && sum >= per_x) begin
         acc_q <= sum - per_x;
         tick  <= 1'b1;
      end else begin
         if (valid) acc_q <= sum;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/zc_phase_timer.sv
// Top: zero-crossing referenced phase timer for a half-bridge resonant stage.
module zc_phase_timer
   import zcpt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int CMD_W       = 8,
   parameter int GD_W        = 8,
   parameter int DEAD_CYC    = 8,
   parameter int TIMEOUT_CYC = 4096,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             zc_in,
   input  logic [CMD_W-1:0] phase_cmd,
   input  logic [GD_W-1:0]  gd_cnt,
   input  logic             samp_x32,
   output logic             hs_gate,
   output logic             ls_gate,
   output logic             cycle_clk,
   output logic             samp_tick,
   output logic             no_sync
);
   generate
      if (DEAD_CYC < 1 || CMD_W < 1 || CNT_W < 7 || GD_W > CNT_W ||
          TIMEOUT_CYC < 2 || TIMEOUT_CYC >= (1 << CNT_W) || SYNC_STAGES < 0) begin : g_bad_cfg
         $error("zc_phase_timer: parameter set out of range");
      end
   endgenerate

   logic             rise, tmo, valid;
   logic [CNT_W-1:0] meas, per_q, dly, half;
   gate_pair_t       gates;
   logic             cyc_q;

   zcpt_period #(
      .CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(SYNC_STAGES)
   ) u_period (
      .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .rise(rise), .tmo(tmo),
      .meas(meas), .per_q(per_q), .valid_q(valid), .no_sync_q(no_sync)
   );

   zcpt_delay #(
      .CNT_W(CNT_W), .CMD_W(CMD_W), .GD_W(GD_W)
   ) u_delay (
      .meas(meas), .cmd(phase_cmd), .tgd(gd_cnt), .dly(dly), .half(half)
   );

   zcpt_gates #(
      .CNT_W(CNT_W), .DEAD_CYC(DEAD_CYC)
   ) u_gates (
      .clk(clk), .rst_n(rst_n), .rise(rise), .valid(valid), .tmo(tmo),
      .dly(dly), .half(half), .gates(gates)
   );

   zcpt_sampler #(
      .CNT_W(CNT_W)
   ) u_sampler (
      .clk(clk), .rst_n(rst_n), .rise(rise), .valid(valid), .x32(samp_x32),
      .per(per_q), .tick(samp_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc_q <= 1'b0;
      else        cyc_q <= rise;
   end

   assign cycle_clk = cyc_q;
   assign hs_gate   = gates.hi;
   assign ls_gate   = gates.lo;
endmodule

// File: rtl/zcpt_checker.sv
// Cycle-level properties of the phase timer outputs.
module zcpt_checker (
   input logic clk,
   input logic rst_n,
   input logic hs_gate,
   input logic ls_gate,
   input logic cycle_clk,
   input logic samp_tick,
   input logic no_sync
);
   a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate && ls_gate));

   a_r4_lo_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_gate) |-> !$past(hs_gate));

   a_r4_hi_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_gate) |-> !$past(ls_gate));

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_clk |=> !cycle_clk);

   a_r6_no_tick_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_clk |-> !samp_tick);

   a_r7_quiet_gates: assert property (@(posedge clk) disable iff (!rst_n)
      no_sync |-> (!hs_gate && !ls_gate));

   a_r7_resync_on_crossing: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(no_sync) |-> cycle_clk);
endmodule

bind zc_phase_timer zcpt_checker u_zcpt_checker (.*);

// File: tb/zc_phase_timer_bench.sv
module zc_phase_timer_bench;
   localparam int M   = 8;
   localparam int DT  = 8;
   localparam int TMO = 4096;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       zc_in = 1'b0;
   logic [7:0] phase_cmd = '0;
   logic [7:0] gd_cnt = '0;
   logic       samp_x32 = 1'b0;
   logic       hs_gate, ls_gate, cycle_clk, samp_tick, no_sync;

   always #10 clk = ~clk;

   zc_phase_timer u_zc_phase_timer (
      .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .phase_cmd(phase_cmd),
      .gd_cnt(gd_cnt), .samp_x32(samp_x32), .hs_gate(hs_gate), .ls_gate(ls_gate),
      .cycle_clk(cycle_clk), .samp_tick(samp_tick), .no_sync(no_sync)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_tag = "R9";
   bit    run_cmp = 0;
   bit    tick_en = 0;
   int    tick_cnt = 0;
   int    tick_exp = 16;

   // behavioural reference, advanced on each rising clock edge
   int e, last_e, pm, per, acc, d, nstep;
   int t_hoff, t_lon, t_loff, t_hon;
   bit zprev, primed, valid, nosync, rise_m, tmo_m, on_lo, nh, nl;
   bit m_hs, m_ls, m_cyc, m_tick;

   always @(posedge clk) begin
      if (!rst_n) begin
         e = 0; last_e = 0; zprev = 0; primed = 0; valid = 0; nosync = 0;
         per = 0; acc = 0; m_hs = 0; m_ls = 0; m_cyc = 0; m_tick = 0;
         t_hoff = -1; t_lon = -1; t_loff = -1; t_hon = -1;
      end else begin
         e++;
         rise_m = zc_in && !zprev;
         zprev  = zc_in;
         tmo_m  = !rise_m && !nosync && (e - last_e == TMO);
         nstep  = samp_x32 ? 32 : 16;
         nh = m_hs; nl = m_ls;
         if (valid) begin
            on_lo = (e == t_lon) && !m_hs;
            if (e == t_hoff) nh = 0;
            if (e == t_loff) nl = 0;
            if (on_lo) nl = 1;
            if (e == t_hon && !m_ls && !on_lo) nh = 1;
         end
         if (tmo_m) begin nh = 0; nl = 0; end
         m_hs = nh; m_ls = nl;
         if (rise_m) begin
            acc = nstep; m_tick = 0;
         end else if (valid) begin
            acc += nstep;
            if (acc >= per) begin acc -= per; m_tick = 1; end
            else m_tick = 0;
         end else begin
            m_tick = 0;
         end
         m_cyc = rise_m;
         if (rise_m) begin
            pm = e - last_e;
            d  = pm / 2 - (pm * int'(phase_cmd)) / (1 << (M + 2)) - int'(gd_cnt);
            if (d < 0) d = 0;
            t_hoff = e + 1 + d;
            t_lon  = t_hoff + DT;
            t_loff = t_hoff + pm / 2;
            t_hon  = t_loff + DT;
            per = pm; valid = primed; primed = 1; nosync = 0; last_e = e;
         end else if (tmo_m) begin
            valid = 0; primed = 0; nosync = 1;
         end
      end
   end

   task automatic check(input logic act, input logic exp, input string req, input string what);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s [%s]: actual %0b expected %0b at %0t", req, what, cur_tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         check(hs_gate, m_hs, "R2", "hs_gate");
         check(ls_gate, m_ls, "R3", "ls_gate");
         check(cycle_clk, m_cyc, "R5", "cycle_clk");
         check(samp_tick, m_tick, "R6", "samp_tick");
         check(no_sync, nosync, "R7", "no_sync");
         check(!(hs_gate && ls_gate), 1'b1, "R4", "gate overlap");
         if (cycle_clk) begin
            if (tick_en) begin
               n_cmp++;
               if (tick_cnt != tick_exp) begin
                  n_bad++;
                  $display("FAIL R6 strobes per period [%s]: actual %0d expected %0d", cur_tag, tick_cnt, tick_exp);
               end
            end
            tick_cnt = 0;
         end else if (samp_tick) begin
            tick_cnt++;
         end
      end
   end

   task automatic drive_period(input int p);
      zc_in = 1'b1;
      repeat (p / 2) @(negedge clk);
      zc_in = 1'b0;
      repeat (p - p / 2) @(negedge clk);
   endtask

   task automatic run_periods(input int p, input int n, input int cmd, input int gd,
                              input bit x32, input string tag);
      tick_en   = 0;
      cur_tag   = tag;
      phase_cmd = 8'(cmd);
      gd_cnt    = 8'(gd);
      samp_x32  = x32;
      tick_exp  = x32 ? 32 : 16;
      for (int i = 0; i < n; i++) begin
         if (i == 2) tick_en = 1;
         drive_period(p);
      end
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      // R9: outputs while reset is held
      check(hs_gate, 1'b0, "R9", "hs_gate in reset");
      check(ls_gate, 1'b0, "R9", "ls_gate in reset");
      check(cycle_clk, 1'b0, "R9", "cycle_clk in reset");
      check(samp_tick, 1'b0, "R9", "samp_tick in reset");
      check(no_sync, 1'b0, "R9", "no_sync in reset");
      rst_n   = 1'b1;
      run_cmp = 1;
      // R1: one crossing alone must not start the gates
      cur_tag   = "R1 first period";
      phase_cmd = 8'd128;
      gd_cnt    = 8'd5;
      drive_period(500);
      check(hs_gate, 1'b0, "R1", "hs_gate before second crossing");
      check(ls_gate, 1'b0, "R1", "ls_gate before second crossing");
      run_periods(500, 6, 128, 5, 1'b0, "R2 R3 mid command");
      run_periods(167, 8, 255, 0, 1'b1, "R2 R3 300 kHz full command");
      run_periods(1667, 5, 0, 20, 1'b0, "R2 R3 30 kHz zero command");
      run_periods(200, 6, 200, 150, 1'b1, "R10 clamp");
      run_periods(600, 4, 64, 3, 1'b0, "R8 long period");
      run_periods(300, 4, 64, 3, 1'b0, "R8 shrink");
      // R7: crossings stop
      tick_en = 0;
      cur_tag = "R7 loss of sync";
      zc_in   = 1'b0;
      repeat (TMO + 200) @(negedge clk);
      check(no_sync, 1'b1, "R7", "no_sync after silence");
      check(hs_gate, 1'b0, "R7", "hs_gate during loss");
      check(ls_gate, 1'b0, "R7", "ls_gate during loss");
      run_periods(400, 5, 100, 2, 1'b1, "R7 recovery");
      repeat (10) @(negedge clk);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            n_bad++;
            $display("FAIL watchdog: run did not complete");
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule